// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This block holds a small register file of two 8-bit accumulators, a 16-bit pair view made of those two accumulators, and three 16-bit pointer registers. It executes single-cycle move, exchange and sign-extend commands between any two of them. It also executes two flag-setting byte moves between the accumulators. Sources and destinations of different widths follow fixed rules. A narrow value going into a wide register is padded with zeros. A wide value going into a narrow register keeps its low byte. A sign-extend replicates bit 7 of the source byte.

A command is given by a valid strobe, a 2-bit operation and two 3-bit register codes. It takes effect on the next rising clock edge. Only the flag-setting byte moves change the N, Z and V condition flags. A test port loads any register directly and reads any register combinationally. This port is how the register file is initialised and how it is observed.

Top module: `regxfer_unit`

## Requirements
- R1: Register codes are A=0, B=1, D=2 (A in bits 15:8, B in bits 7:0), X=3, Y=4, SP=5. Operation codes are move=0, exchange=1, sign-extend=2, flagged byte move=3. A move from A or B into D, X, Y or SP writes the byte into bits 7:0 and zeros into bits 15:8.
- R2: A move from D, X, Y or SP into A or B writes only bits 7:0 of the source.
- R3: An exchange of two registers of the same width swaps them on one edge. An exchange of an accumulator with X, Y or SP gives the accumulator the register's low byte and gives the register 0x00 above the old accumulator value.
- R4: Writing D writes A and B. When an exchange writes both D and A or B, the accumulator's own write takes precedence over the D byte it overlaps. So exchanging A with D swaps A and B, and exchanging B with D leaves B and clears A.
- R5: Sign-extend takes bits 7:0 of the source. It writes them to the destination with bit 7 copied into bits 15:8, and a narrow destination keeps bits 7:0.
- R6: Move, exchange and sign-extend commands leave N, Z and V unchanged.
- R7: The flagged byte move from A to B, or from B to A, copies the byte. It sets N to bit 7 of the byte, sets Z when the byte is zero, and clears V. With any other register pair, code 3 changes no register and no flag.
- R8: A command naming code 6 or 7 as source or destination is ignored. A move whose source and destination are the same register leaves every register unchanged.
- R9: A command completes on one edge and reads every source before any destination is written. A test-port load in the same cycle takes precedence and the command is dropped. Reset clears all registers and flags.
- R10: The test-port read returns the selected register with narrow registers zero-extended and D as A:B. A test-port load writes the low byte into A or B, and writes both bytes into D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code |
| cmd_src | input | 3 | Source register code |
| cmd_dst | input | 3 | Destination register code |
| tp_load | input | 1 | Test-port register load |
| tp_sel | input | 3 | Test-port register code |
| tp_wdata | input | 16 | Test-port load data |
| tp_rdata | output | 16 | Test-port read data for tp_sel |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The register and flag effects of a command or load presented before a rising edge are due right after that edge. The test-port read is combinational from the register file, so it reflects a change in the same cycle as the edge, with no further delay. The bench drives each command at a falling edge and updates its reference model one time step after the next rising edge. Within that same cycle it then sweeps tp_sel across all six registers and compares each value and the three flags.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CODE_W = 3;
  localparam int OP_W   = 2;
  localparam int NUM_RD = 3;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [CODE_W-1:0] {
    RG_A = 3'd0, RG_B = 3'd1, RG_D = 3'd2, RG_X = 3'd3,
    RG_Y = 3'd4, RG_SP = 3'd5, RG_R6 = 3'd6, RG_R7 = 3'd7
  } rsel_t;

  typedef enum logic [OP_W-1:0] {
    OP_MOVE = 2'd0, OP_SWAP = 2'd1, OP_SEXT = 2'd2, OP_LEG = 2'd3
  } xop_t;

  typedef struct packed {
    byte_t acc_a;
    byte_t acc_b;
    word_t ptr_x;
    word_t ptr_y;
    word_t ptr_sp;
  } rfile_t;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return c <= RG_SP;
  endfunction

  function automatic logic code_narrow(input logic [CODE_W-1:0] c);
    return (c == RG_A) || (c == RG_B);
  endfunction

  function automatic word_t zext(input byte_t v);
    return {{BYTE_W{1'b0}}, v};
  endfunction

  function automatic word_t sext(input byte_t v);
    return {{BYTE_W{v[BYTE_W-1]}}, v};
  endfunction

  function automatic word_t rf_read(input rfile_t r, input logic [CODE_W-1:0] c);
    word_t v;
    case (c)
      RG_A:    v = zext(r.acc_a);
      RG_B:    v = zext(r.acc_b);
      RG_D:    v = {r.acc_a, r.acc_b};
      RG_X:    v = r.ptr_x;
      RG_Y:    v = r.ptr_y;
      RG_SP:   v = r.ptr_sp;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic rfile_t rf_write(input rfile_t r, input logic [CODE_W-1:0] c,
                                      input word_t v);
    rfile_t o;
    o = r;
    case (c)
      RG_A:    o.acc_a = v[BYTE_W-1:0];
      RG_B:    o.acc_b = v[BYTE_W-1:0];
      RG_D:    {o.acc_a, o.acc_b} = v;
      RG_X:    o.ptr_x = v;
      RG_Y:    o.ptr_y = v;
      RG_SP:   o.ptr_sp = v;
      default: o = r;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/regxfer_rdport.sv
module regxfer_rdport
  import regxfer_pkg::*;
(
  input  rfile_t              rf,
  input  logic [CODE_W-1:0]   sel,
  output word_t               val
);
  assign val = rf_read(rf, sel);
endmodule

// File: rtl/regxfer_exec.sv
module regxfer_exec
  import regxfer_pkg::*;
(
  input  rfile_t            rf,
  input  logic              cmd_live,
  input  logic [OP_W-1:0]   op,
  input  logic [CODE_W-1:0] src,
  input  logic [CODE_W-1:0] dst,
  input  word_t             src_val,
  input  word_t             dst_val,
  output rfile_t            rf_nxt,
  output logic              ev_move,
  output logic              ev_swap,
  output logic              ev_sext,
  output logic              ev_legacy,
  output logic              ev_ignored,
  output byte_t             leg_byte
);
  logic codes_ok;
  logic leg_pair;
  logic src_first_narrow;

  assign codes_ok  = cmd_live && code_ok(src) && code_ok(dst);
  assign leg_pair  = ((src == RG_A) && (dst == RG_B)) || ((src == RG_B) && (dst == RG_A));
  assign ev_move   = codes_ok && (op == OP_MOVE);
  assign ev_swap   = codes_ok && (op == OP_SWAP);
  assign ev_sext   = codes_ok && (op == OP_SEXT);
  assign ev_legacy = codes_ok && (op == OP_LEG) && leg_pair;
  assign ev_ignored = cmd_live && !(ev_move || ev_swap || ev_sext || ev_legacy);
  assign leg_byte  = src_val[BYTE_W-1:0];

  // wide writes land first so an overlapping accumulator write wins
  assign src_first_narrow = code_narrow(src) && !code_narrow(dst);

  always_comb begin
    rf_nxt = rf;
    if (ev_move || ev_legacy) begin
      rf_nxt = rf_write(rf, dst, src_val);
    end else if (ev_sext) begin
      rf_nxt = rf_write(rf, dst, sext(src_val[BYTE_W-1:0]));
    end else if (ev_swap) begin
      if (src_first_narrow) begin
        rf_nxt = rf_write(rf_write(rf, dst, src_val), src, dst_val);
      end else begin
        rf_nxt = rf_write(rf_write(rf, src, dst_val), dst, src_val);
      end
    end
  end
endmodule

// File: rtl/regxfer_unit.sv
module regxfer_unit
  import regxfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [CODE_W-1:0] cmd_src,
  input  logic [CODE_W-1:0] cmd_dst,
  input  logic              tp_load,
  input  logic [CODE_W-1:0] tp_sel,
  input  logic [WORD_W-1:0] tp_wdata,
  output logic [WORD_W-1:0] tp_rdata,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v
);
  rfile_t rf_q;
  rfile_t rf_nxt;
  logic   cmd_live;
  logic   ev_move, ev_swap, ev_sext, ev_legacy, ev_ignored;
  byte_t  leg_byte;
  word_t  rd_val [NUM_RD];
  logic [CODE_W-1:0] rd_sel [NUM_RD];

  assign cmd_live = cmd_valid && !tp_load;
  assign rd_sel[0] = cmd_src;
  assign rd_sel[1] = cmd_dst;
  assign rd_sel[2] = tp_sel;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_RD; gi++) begin : g_rd
      regxfer_rdport u_rd (.rf(rf_q), .sel(rd_sel[gi]), .val(rd_val[gi]));
    end
  endgenerate

  regxfer_exec u_exec (
    .rf(rf_q), .cmd_live(cmd_live), .op(cmd_op), .src(cmd_src), .dst(cmd_dst),
    .src_val(rd_val[0]), .dst_val(rd_val[1]), .rf_nxt(rf_nxt),
    .ev_move(ev_move), .ev_swap(ev_swap), .ev_sext(ev_sext),
    .ev_legacy(ev_legacy), .ev_ignored(ev_ignored), .leg_byte(leg_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q   <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
    end else begin
      if (tp_load) begin
        rf_q <= rf_write(rf_q, tp_sel, tp_wdata);
      end else begin
        rf_q <= rf_nxt;
      end
      if (ev_legacy) begin
        flag_n <= leg_byte[BYTE_W-1];
        flag_z <= (leg_byte == '0);
        flag_v <= 1'b0;
      end
    end
  end

  assign tp_rdata = rd_val[2];
endmodule

// File: rtl/regxfer_chk.sv
module regxfer_chk
  import regxfer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input rfile_t            rf_q,
  input logic              ev_move,
  input logic              ev_swap,
  input logic              ev_sext,
  input logic              ev_legacy,
  input logic              ev_ignored,
  input byte_t             leg_byte,
  input logic [CODE_W-1:0] cmd_dst,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v
);
  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_legacy |=> $stable({flag_n, flag_z, flag_v}));

  // R7
  legacy_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_legacy |=> (flag_n == $past(leg_byte[BYTE_W-1])) &&
                  (flag_z == ($past(leg_byte) == '0)) && !flag_v);

  // R8
  ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ignored |=> $stable(rf_q));

  // R9
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_move, ev_swap, ev_sext, ev_legacy, ev_ignored}));

  // R5
  sext_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sext && (cmd_dst == RG_X)) |=>
      (rf_q.ptr_x[WORD_W-1:BYTE_W] == {BYTE_W{$past(leg_byte[BYTE_W-1])}}));
endmodule

bind regxfer_unit regxfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rf_q(rf_q), .ev_move(ev_move), .ev_swap(ev_swap),
  .ev_sext(ev_sext), .ev_legacy(ev_legacy), .ev_ignored(ev_ignored),
  .leg_byte(leg_byte), .cmd_dst(cmd_dst), .flag_n(flag_n), .flag_z(flag_z),
  .flag_v(flag_v)
);

// File: tb/tb_regxfer_unit.sv
module tb_regxfer_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [2:0]  cmd_src = 0;
  logic [2:0]  cmd_dst = 0;
  logic        tp_load = 0;
  logic [2:0]  tp_sel = 0;
  logic [15:0] tp_wdata = 0;
  logic [15:0] tp_rdata;
  logic        flag_n, flag_z, flag_v;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  logic [7:0]  ma, mb;
  logic [15:0] mx, my, ms;
  logic        fn, fz, fv;

  regxfer_unit dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] m_get(int c);
    case (c)
      0: return {8'h00, ma};
      1: return {8'h00, mb};
      2: return {ma, mb};
      3: return mx;
      4: return my;
      5: return ms;
      default: return 16'h0;
    endcase
  endfunction

  task automatic m_put(int c, logic [15:0] v);
    case (c)
      0: ma = v[7:0];
      1: mb = v[7:0];
      2: begin ma = v[15:8]; mb = v[7:0]; end
      3: mx = v;
      4: my = v;
      5: ms = v;
      default: ;
    endcase
  endtask

  task automatic m_step(int op, int s, int d);
    logic [15:0] sv, dv;
    int wc[2];
    logic [15:0] wv[2];
    if (s > 5 || d > 5) return;            // R8 reserved codes
    sv = m_get(s);
    dv = m_get(d);
    case (op)
      0: m_put(d, sv);
      1: begin
        wc[0] = d; wv[0] = sv; wc[1] = s; wv[1] = dv;
        for (int pass = 0; pass < 2; pass++)        // wide targets, then bytes
          for (int k = 0; k < 2; k++)
            if ((wc[k] <= 1) == (pass == 1)) m_put(wc[k], wv[k]);
      end
      2: m_put(d, (sv[7:0] >= 8'd128) ? (16'hFF00 + 16'(sv[7:0])) : 16'(sv[7:0]));
      default: if ((s == 0 && d == 1) || (s == 1 && d == 0)) begin
        m_put(d, sv);
        fn = (sv[7:0] >= 8'd128);
        fz = (sv[7:0] == 8'd0);
        fv = 1'b0;
      end
    endcase
  endtask

  task automatic chk(logic [15:0] act, logic [15:0] exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 6; i++) begin
      tp_sel = 3'(i);
      #1;
      chk(tp_rdata, m_get(i), tag, $sformatf("reg%0d", i));
    end
    chk({13'b0, flag_n, flag_z, flag_v}, {13'b0, fn, fz, fv}, tag, "flags");
  endtask

  task automatic load(int c, logic [15:0] v, string tag);
    @(negedge clk);
    tp_load = 1; tp_sel = 3'(c); tp_wdata = v;
    @(posedge clk); #1;
    tp_load = 0;
    m_put(c, v);
    check_all(tag);
  endtask

  task automatic cmd(int op, int s, int d, string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_src = 3'(s); cmd_dst = 3'(d);
    @(posedge clk); #1;
    cmd_valid = 0;
    m_step(op, s, d);
    check_all(tag);
  endtask

  initial begin
    ma = 0; mb = 0; mx = 0; my = 0; ms = 0; fn = 0; fz = 0; fv = 0;
    repeat (3) @(posedge clk);
    #1 check_all("R9 reset");
    @(negedge clk) rst_n = 1;

    load(0, 16'h3381, "R10 load A low byte");
    load(1, 16'h0000, "R10 load B");
    load(3, 16'h1234, "R10 load X");
    load(4, 16'hBEEF, "R10 load Y");
    load(5, 16'h0F00, "R10 load SP");
    cmd(0, 0, 3, "R1 move A to X zero-extend");
    cmd(0, 4, 1, "R2 move Y to B truncate");
    cmd(0, 0, 2, "R4 move A to D");
    load(2, 16'hA55A, "R10 load D");
    cmd(1, 0, 5, "R3 exchange A with SP");
    cmd(1, 3, 4, "R3 exchange X with Y");
    cmd(1, 0, 1, "R3 exchange A with B");
    cmd(1, 0, 2, "R4 exchange A with D");
    cmd(1, 1, 2, "R4 exchange B with D");
    cmd(1, 2, 3, "R4 exchange D with X");
    load(0, 16'h0080, "R10 load A");
    cmd(2, 0, 3, "R5 sign-extend negative");
    load(1, 16'h007F, "R10 load B");
    cmd(2, 1, 4, "R5 sign-extend positive");
    cmd(2, 4, 0, "R5 sign-extend into narrow");
    load(0, 16'h0000, "R10 load A zero");
    cmd(3, 0, 1, "R7 flagged move zero byte");
    load(1, 16'h00C3, "R10 load B");
    cmd(3, 1, 0, "R7 flagged move negative byte");
    cmd(0, 3, 5, "R6 move keeps flags");
    cmd(1, 0, 4, "R6 exchange keeps flags");
    cmd(3, 3, 4, "R7 flagged op on wide pair ignored");
    cmd(0, 6, 3, "R8 reserved source ignored");
    cmd(1, 2, 7, "R8 reserved destination ignored");
    cmd(0, 4, 4, "R8 move to itself");
    cmd(0, 2, 2, "R8 move D to itself");

    // R9 test load and command in the same cycle: load wins
    @(negedge clk);
    tp_load = 1; tp_sel = 3'd3; tp_wdata = 16'h7E7E;
    cmd_valid = 1; cmd_op = 2'd0; cmd_src = 3'd4; cmd_dst = 3'd3;
    @(posedge clk); #1;
    tp_load = 0; cmd_valid = 0;
    m_put(3, 16'h7E7E);
    check_all("R9 load wins over command");

    for (int n = 0; n < 300; n++) begin
      if (n % 10 == 0) load(int'($urandom_range(0, 5)), 16'($urandom), "R10 random load");
      cmd(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
          int'($urandom_range(0, 7)), "R9 random command");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule